// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits beside the fetch logic of an 8-bit accumulator processor. At every instruction boundary it chooses between the next opcode and an interrupt entry. It takes an interrupt entry if an edge-latched non-maskable request is pending, if a restart request is pending, or if a level-sensitive maskable request is present while the interrupt-disable flag is clear. A software break opcode seen at the boundary also takes an entry. Once it has chosen an entry, the block owns the memory port for seven cycles. It saves the return state on the stack, fetches the two vector bytes and hands back the new program counter, stack pointer and status byte.

The block snapshots the program counter, stack pointer and status byte given on its inputs at the boundary, and then works on its own copies. The memory port is a single synchronous port. The address and write data are valid for the whole cycle, and read data for the presented address must be valid before the closing clock edge. The processor core copies `pc_out`, `sp_out` and `st_out` back into its own registers in the cycle where `done` is high.

Top module: `intr_entry_seq`

## Requirements
- R1: At a boundary cycle while idle, the winner is chosen in this order: pending non-maskable request, then pending restart, then maskable request (only if status bit 2 is clear), then break request. A boundary pulse while a sequence runs is ignored, and the running sequence keeps its source.
- R2: A sequence lasts seven cycles (steps 0 to 6). Steps 0 and 1 are reads at the program counter; for a break, step 1 reads at PC+1. Step 5 reads the vector low byte and step 6 reads the vector high byte. Steps 0, 1, 5 and 6 never write.
- R3: Steps 2, 3 and 4 address 0x0100 plus the current stack pointer and carry PC high byte, PC low byte and status byte, in that order. The stack pointer drops by one after each of these steps and wraps within 8 bits, so it ends three below its starting value.
- R4: For non-maskable and maskable entries, the pushed status and the returned status both equal the input status with bit 2 set and bit 4 cleared.
- R5: A break entry pushes PC+1. The pushed status and the returned status are the input status with bit 4 set and bit 2 unchanged. The new PC is taken from the maskable vector.
- R6: A restart entry forces the stack pointer to 0xFF before step 2 and performs steps 2 to 4 as reads with no write, so the stack pointer ends at 0xFC. The returned status is the input status with bit 2 set.
- R7: Vector addresses are 0xFFFA/0xFFFB for non-maskable, 0xFFFC/0xFFFD for restart, and 0xFFFE/0xFFFF for maskable and break. The new PC is the high byte read in step 6 joined above the low byte read in step 5.
- R8: A rising edge on `nmi_req` sets a pending flag. A `rst_req` pulse, or the active-low reset, sets the restart pending flag. Each flag stays set until the final step of its own sequence, and holding `nmi_req` high does not retrigger it.
- R9: The maskable request is sampled only as a level at the boundary. It is never latched, and it is refused while status bit 2 is set.
- R10: `busy` is high for exactly the seven steps. `done` is high for the single cycle after step 6, and `pc_out` holds the new PC in that cycle.
- R11: After the active-low reset, `busy`, `done` and `mem_we` are low, and the first boundary takes a restart entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boundary | input | 1 | Instruction boundary strobe from the core |
| nmi_req | input | 1 | Non-maskable request, edge-latched |
| rst_req | input | 1 | Restart request pulse |
| irq_lvl | input | 1 | Maskable request level |
| brk_req | input | 1 | Break opcode present at this boundary |
| pc_in | input | 16 | Program counter at the boundary |
| sp_in | input | 8 | Stack pointer at the boundary |
| st_in | input | 8 | Status byte at the boundary |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read data for the presented address |
| pc_out | output | 16 | New program counter |
| sp_out | output | 8 | Stack pointer after the pushes |
| st_out | output | 8 | Status byte after entry |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the new PC is valid |

## Verification
Some properties are checked on every cycle. Writes stay inside the stack page. Each push step lowers the stack pointer by exactly one. A restart sequence never writes. A running sequence keeps its source and ignores new boundaries. `done` is a single pulse that closes a sequence. At most one source is granted, and a pending non-maskable request persists until it is cleared. Other behaviour can only be shown by the bench scenarios: the full priority order, and the exact addresses, pushed bytes and vector values of each entry kind. The same goes for stack wrap-around at 0x01, an edge arriving in the middle of another sequence, a level-held edge source that must not retrigger, and a maskable pulse that drops before the boundary.

// File: rtl/intr_entry_pkg.sv
// Package: shared types and constants for the interrupt entry sequencer.
// Assumes an 8-bit data path and a 16-bit address space.
package intr_entry_pkg;

    localparam int DW = 8;
    localparam int AW = 2 * DW;

    // Status bit positions that the entry sequence modifies.
    localparam int FLAG_MASK  = 2;
    localparam int FLAG_SOFT  = 4;

    // Entry source, in priority order (lowest value wins).
    typedef enum logic [1:0] {
        SRC_NMI = 2'd0,
        SRC_RST = 2'd1,
        SRC_IRQ = 2'd2,
        SRC_BRK = 2'd3
    } src_e;

    localparam int NSRC = 4;

    // Address of the vector low byte for a source, relative to the base.
    function automatic logic [AW-1:0] vec_addr(input src_e s, input logic [AW-1:0] base);
        case (s)
            SRC_NMI: return base;
            SRC_RST: return base + AW'(2);
            default: return base + AW'(4);
        endcase
    endfunction

endpackage

// File: rtl/intr_pend.sv
// Module: holds the pending flags for the non-maskable and restart sources.
// The non-maskable flag is set on a rising request edge. The restart flag is set
// by a request pulse or by the block reset. A new set wins over a clear in the same cycle.
module intr_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_req,
    input  logic rst_req,
    input  logic clr_nmi,
    input  logic clr_rst,
    output logic nmi_pend,
    output logic rst_pend
);

    logic nmi_q;

    // Edge detect and pending-flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q    <= 1'b0;
            nmi_pend <= 1'b0;
            rst_pend <= 1'b1;
        end else begin
            nmi_q    <= nmi_req;
            nmi_pend <= (nmi_req && !nmi_q) || (nmi_pend && !clr_nmi);
            rst_pend <= rst_req || (rst_pend && !clr_rst);
        end
    end

    // R8: a pending edge is kept until its own sequence clears it.
    p_nmi_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend && !clr_nmi) |=> nmi_pend);

    // R8: the flag only rises after the request input was high.
    p_nmi_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_pend) |-> $past(nmi_req));

endmodule

// File: rtl/intr_arb.sv
// Module: fixed-priority selection among the four entry sources.
// It is purely combinational. The maskable request is gated by the mask flag.
module intr_arb
    import intr_entry_pkg::*;
(
    input  logic nmi_pend,
    input  logic rst_pend,
    input  logic irq_lvl,
    input  logic mask_flag,
    input  logic brk_req,
    output logic take,
    output src_e src
);

    logic [NSRC-1:0] req;
    logic [NSRC-1:0] grant;

    // Build the request vector in priority order.
    always_comb begin
        req[SRC_NMI] = nmi_pend;
        req[SRC_RST] = rst_pend;
        req[SRC_IRQ] = irq_lvl && !mask_flag;
        req[SRC_BRK] = brk_req;
    end

    // One grant per source: a source wins when no higher source requests.
    for (genvar g = 0; g < NSRC; g++) begin : g_grant
        if (g == 0) begin : g_top
            assign grant[g] = req[g];
        end else begin : g_low
            assign grant[g] = req[g] && !(|req[g-1:0]);
        end
    end

    // Encode the grant into a source value.
    always_comb begin
        take = |grant;
        src  = SRC_BRK;
        for (int k = NSRC - 1; k >= 0; k--) begin
            if (grant[k]) src = src_e'(k);
        end
    end

    // R1: never more than one winner.
    always_comb begin
        if (!$isunknown(req)) begin
            p_one_winner_r1: assert ($onehot0(grant));
        end
    end

endmodule

// File: rtl/intr_bus.sv
// Module: drives the memory port from the current step of the sequence.
// It is combinational. It assumes the stack is one 256-byte page that the
// stack pointer indexes.
module intr_bus
    import intr_entry_pkg::*;
#(
    parameter int            SW         = 3,
    parameter logic [DW-1:0] STACK_PAGE = 8'h01,
    parameter logic [AW-1:0] VEC_BASE   = 16'hFFFA
) (
    input  logic          busy,
    input  logic [SW-1:0] step,
    input  src_e          src,
    input  logic [AW-1:0] pc,
    input  logic [DW-1:0] sp,
    input  logic [DW-1:0] push_st,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic          we
);

    logic [AW-1:0] vec;
    logic          push_ok;

    assign vec     = vec_addr(src, VEC_BASE);
    assign push_ok = (src != SRC_RST);

    // Address, data and write strobe for each step.
    always_comb begin
        addr  = pc;
        wdata = '0;
        we    = 1'b0;
        if (busy) begin
            if (step == SW'(2)) begin
                addr  = {STACK_PAGE, sp};
                wdata = pc[AW-1:DW];
                we    = push_ok;
            end else if (step == SW'(3)) begin
                addr  = {STACK_PAGE, sp};
                wdata = pc[DW-1:0];
                we    = push_ok;
            end else if (step == SW'(4)) begin
                addr  = {STACK_PAGE, sp};
                wdata = push_st;
                we    = push_ok;
            end else if (step == SW'(5)) begin
                addr  = vec;
            end else if (step == SW'(6)) begin
                addr  = vec + AW'(1);
            end
        end
    end

endmodule

// File: rtl/intr_entry_seq.sv
// Module: top of the interrupt entry sequencer. At an idle boundary it picks a
// source, snapshots PC, S and status, and runs seven bus steps. It then returns
// the new PC, S and status, with a one-cycle done pulse.
// Assumes read data is valid before the edge that closes the cycle in which its
// address is presented.
module intr_entry_seq
    import intr_entry_pkg::*;
#(
    parameter logic [7:0]  STACK_PAGE = 8'h01,
    parameter logic [15:0] VEC_BASE   = 16'hFFFA
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        boundary,
    input  logic        nmi_req,
    input  logic        rst_req,
    input  logic        irq_lvl,
    input  logic        brk_req,
    input  logic [15:0] pc_in,
    input  logic [7:0]  sp_in,
    input  logic [7:0]  st_in,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        mem_we,
    input  logic [7:0]  mem_rdata,
    output logic [15:0] pc_out,
    output logic [7:0]  sp_out,
    output logic [7:0]  st_out,
    output logic        busy,
    output logic        done
);

    localparam int            STEPS  = 7;
    localparam int            SW     = $clog2(STEPS);
    localparam logic [SW-1:0] S_LAST = SW'(STEPS - 1);

    logic [SW-1:0] step;
    src_e          src_r;
    src_e          arb_src;
    logic          arb_take;
    logic [AW-1:0] pc_r;
    logic [DW-1:0] sp_r;
    logic [DW-1:0] st_r;
    logic [DW-1:0] st_new;
    logic [DW-1:0] vlo_r;
    logic          nmi_pend;
    logic          rst_pend;
    logic          last;

    assign last = busy && (step == S_LAST);

    intr_pend u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi_req  (nmi_req),
        .rst_req  (rst_req),
        .clr_nmi  (last && (src_r == SRC_NMI)),
        .clr_rst  (last && (src_r == SRC_RST)),
        .nmi_pend (nmi_pend),
        .rst_pend (rst_pend)
    );

    intr_arb u_arb (
        .nmi_pend  (nmi_pend),
        .rst_pend  (rst_pend),
        .irq_lvl   (irq_lvl),
        .mask_flag (st_in[FLAG_MASK]),
        .brk_req   (brk_req),
        .take      (arb_take),
        .src       (arb_src)
    );

    // Status after entry. It is also the byte pushed in step 4.
    always_comb begin
        st_new = st_r;
        case (src_r)
            SRC_RST: st_new[FLAG_MASK] = 1'b1;
            SRC_BRK: st_new[FLAG_SOFT] = 1'b1;
            default: begin
                st_new[FLAG_MASK] = 1'b1;
                st_new[FLAG_SOFT] = 1'b0;
            end
        endcase
    end

    intr_bus #(
        .SW         (SW),
        .STACK_PAGE (STACK_PAGE),
        .VEC_BASE   (VEC_BASE)
    ) u_bus (
        .busy    (busy),
        .step    (step),
        .src     (src_r),
        .pc      (pc_r),
        .sp      (sp_r),
        .push_st (st_new),
        .addr    (mem_addr),
        .wdata   (mem_wdata),
        .we      (mem_we)
    );

    // Sequence state: start on a granted boundary, then advance one step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            step  <= '0;
            src_r <= SRC_NMI;
            pc_r  <= '0;
            sp_r  <= '0;
            st_r  <= '0;
            vlo_r <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (boundary && arb_take) begin
                    busy  <= 1'b1;
                    step  <= '0;
                    src_r <= arb_src;
                    pc_r  <= pc_in;
                    sp_r  <= (arb_src == SRC_RST) ? '1 : sp_in;
                    st_r  <= st_in;
                end
            end else begin
                step <= step + SW'(1);
                if (step == SW'(0) && src_r == SRC_BRK) begin
                    pc_r <= pc_r + AW'(1);
                end
                if (step >= SW'(2) && step <= SW'(4)) begin
                    sp_r <= sp_r - DW'(1);
                end
                if (step == SW'(4)) begin
                    st_r <= st_new;
                end
                if (step == SW'(5)) begin
                    vlo_r <= mem_rdata;
                end
                if (last) begin
                    pc_r <= {mem_rdata, vlo_r};
                    busy <= 1'b0;
                    done <= 1'b1;
                    step <= '0;
                end
            end
        end
    end

    assign pc_out = pc_r;
    assign sp_out = sp_r;
    assign st_out = st_r;

    // R3: writes land only in the stack page.
    p_stack_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[AW-1:DW] == STACK_PAGE));

    // R3: each stack step lowers S by exactly one.
    p_sp_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && step >= SW'(2) && step <= SW'(4)) |=> (sp_r == $past(sp_r) - DW'(1)));

    // R6: a restart sequence never writes memory.
    p_reset_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && src_r == SRC_RST) |-> !mem_we);

    // R1: a running sequence keeps going with the same source.
    p_busy_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> (busy && $stable(src_r)));

    // R10: done is a single pulse.
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: done closes a sequence.
    p_done_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

endmodule

// File: tb/tb_intr_entry_seq.sv
`timescale 1ns/1ps
module tb_intr_entry_seq;

    localparam int K_NMI = 0;
    localparam int K_RST = 1;
    localparam int K_IRQ = 2;
    localparam int K_BRK = 3;

    typedef struct packed {
        logic        nmi;
        logic        rst;
        logic        irq;
        logic        brk;
        logic [7:0]  st;
        logic [15:0] pc;
        logic [7:0]  sp;
        logic        take;
        logic [1:0]  kind;
    } case_t;

    localparam int NCASE = 8;
    localparam case_t CASES [NCASE] = '{
        '{1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 16'h1234, 8'h40, 1'b1, 2'd1},
        '{1'b1, 1'b0, 1'b1, 1'b0, 8'h30, 16'h8000, 8'h80, 1'b1, 2'd0},
        '{1'b0, 1'b0, 1'b1, 1'b1, 8'h01, 16'h4567, 8'h10, 1'b1, 2'd2},
        '{1'b0, 1'b0, 1'b1, 1'b0, 8'h04, 16'h0F00, 8'h20, 1'b0, 2'd2},
        '{1'b0, 1'b0, 1'b1, 1'b1, 8'h04, 16'h2000, 8'h30, 1'b1, 2'd3},
        '{1'b1, 1'b1, 1'b0, 1'b0, 8'h80, 16'h9ABC, 8'h60, 1'b1, 2'd0},
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'hC3, 16'h0000, 8'h00, 1'b1, 2'd1},
        '{1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 16'hBEEF, 8'h01, 1'b1, 2'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary = 1'b0;
    logic        nmi_req = 1'b0;
    logic        rst_req = 1'b0;
    logic        irq_lvl = 1'b0;
    logic        brk_req = 1'b0;
    logic [15:0] pc_in = '0;
    logic [7:0]  sp_in = '0;
    logic [7:0]  st_in = '0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  mem_rdata;
    logic [15:0] pc_out;
    logic [7:0]  sp_out;
    logic [7:0]  st_out;
    logic        busy;
    logic        done;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    intr_entry_seq dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .boundary  (boundary),
        .nmi_req   (nmi_req),
        .rst_req   (rst_req),
        .irq_lvl   (irq_lvl),
        .brk_req   (brk_req),
        .pc_in     (pc_in),
        .sp_in     (sp_in),
        .st_in     (st_in),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .pc_out    (pc_out),
        .sp_out    (sp_out),
        .st_out    (st_out),
        .busy      (busy),
        .done      (done)
    );

    // Memory model: fixed vector bytes, filler elsewhere.
    always_comb begin
        case (mem_addr)
            16'hFFFA: mem_rdata = 8'h11;
            16'hFFFB: mem_rdata = 8'h22;
            16'hFFFC: mem_rdata = 8'h33;
            16'hFFFD: mem_rdata = 8'h44;
            16'hFFFE: mem_rdata = 8'h55;
            16'hFFFF: mem_rdata = 8'h66;
            default:  mem_rdata = 8'hEA;
        endcase
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Run one table entry and check every bus step and the returned state.
    task automatic run_case(input case_t c);
        logic [15:0] ra [7];
        logic        rw [7];
        logic [7:0]  rd [7];
        logic [7:0]  sp0;
        logic [15:0] ppc;
        logic [15:0] vec;
        logic [15:0] npc;
        logic [7:0]  live;
        string       tag;
        @(negedge clk);
        nmi_req = c.nmi;
        rst_req = c.rst;
        @(negedge clk);
        nmi_req  = 1'b0;
        rst_req  = 1'b0;
        irq_lvl  = c.irq;
        brk_req  = c.brk;
        st_in    = c.st;
        pc_in    = c.pc;
        sp_in    = c.sp;
        boundary = 1'b1;
        @(negedge clk);
        boundary = 1'b0;
        if (!c.take) begin
            chk("R9 masked request not taken", 32'(busy), 32'd0);
            irq_lvl = 1'b0;
            brk_req = 1'b0;
            return;
        end
        chk("R1 entry started", 32'(busy), 32'd1);
        for (int k = 0; k < 7; k++) begin
            ra[k] = mem_addr;
            rw[k] = mem_we;
            rd[k] = mem_wdata;
            @(negedge clk);
        end
        sp0 = (c.kind == 2'(K_RST)) ? 8'hFF : c.sp;
        ppc = (c.kind == 2'(K_BRK)) ? c.pc + 16'd1 : c.pc;
        case (c.kind)
            2'(K_NMI): begin vec = 16'hFFFA; npc = 16'h2211; tag = "R4"; end
            2'(K_RST): begin vec = 16'hFFFC; npc = 16'h4433; tag = "R6"; end
            2'(K_IRQ): begin vec = 16'hFFFE; npc = 16'h6655; tag = "R4"; end
            default:   begin vec = 16'hFFFE; npc = 16'h6655; tag = "R5"; end
        endcase
        live = c.st;
        if (c.kind == 2'(K_RST))      live = c.st | 8'h04;
        else if (c.kind == 2'(K_BRK)) live = c.st | 8'h10;
        else                          live = (c.st | 8'h04) & 8'hEF;
        chk("R2 step0 address", 32'(ra[0]), 32'(c.pc));
        chk("R2 step1 address", 32'(ra[1]), 32'(ppc));
        chk("R2 no write in fetch/vector steps", 32'({rw[0], rw[1], rw[5], rw[6]}), 32'd0);
        chk("R3 stack address step2", 32'(ra[2]), 32'({8'h01, sp0}));
        chk("R3 stack address step3", 32'(ra[3]), 32'({8'h01, 8'(sp0 - 8'd1)}));
        chk("R3 stack address step4", 32'(ra[4]), 32'({8'h01, 8'(sp0 - 8'd2)}));
        if (c.kind == 2'(K_RST)) begin
            chk("R6 stack steps are reads", 32'({rw[2], rw[3], rw[4]}), 32'd0);
        end else begin
            chk("R3 stack steps write", 32'({rw[2], rw[3], rw[4]}), 32'h7);
            chk("R3 pushed PC high", 32'(rd[2]), 32'(ppc[15:8]));
            chk("R3 pushed PC low", 32'(rd[3]), 32'(ppc[7:0]));
            chk({tag, " pushed status"}, 32'(rd[4]), 32'(live));
        end
        chk("R7 vector low address", 32'(ra[5]), 32'(vec));
        chk("R7 vector high address", 32'(ra[6]), 32'(vec + 16'd1));
        chk("R10 done pulse", 32'(done), 32'd1);
        chk("R10 busy cleared", 32'(busy), 32'd0);
        chk("R7 new PC", 32'(pc_out), 32'(npc));
        chk("R3 final stack pointer", 32'(sp_out), 32'(8'(sp0 - 8'd3)));
        chk({tag, " returned status"}, 32'(st_out), 32'(live));
        irq_lvl = 1'b0;
        brk_req = 1'b0;
        @(negedge clk);
        chk("R10 done lasts one cycle", 32'(done), 32'd0);
    endtask

    initial begin
        #(20 * 50000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: idle state after reset.
        chk("R11 busy after reset", 32'(busy), 32'd0);
        chk("R11 done after reset", 32'(done), 32'd0);
        chk("R11 no write after reset", 32'(mem_we), 32'd0);

        for (int i = 0; i < NCASE; i++) begin
            run_case(CASES[i]);
        end

        // R1: a boundary during a sequence is ignored; the NMI edge stays pending (R8).
        @(negedge clk);
        irq_lvl = 1'b1; brk_req = 1'b0; st_in = 8'h00; pc_in = 16'h3000; sp_in = 8'h50;
        boundary = 1'b1;
        @(negedge clk);
        boundary = 1'b0; irq_lvl = 1'b0;
        @(negedge clk);
        @(negedge clk);
        nmi_req = 1'b1; boundary = 1'b1;
        @(negedge clk);
        nmi_req = 1'b0; boundary = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 mid-sequence boundary ignored, done", 32'(done), 32'd1);
        chk("R1 mid-sequence source kept", 32'(pc_out), 32'h6655);
        chk("R1 stack pointer of first entry", 32'(sp_out), 32'h4D);
        run_case('{1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 16'h7777, 8'h22, 1'b1, 2'd0});

        // R8: a held-high NMI request does not trigger again.
        @(negedge clk);
        nmi_req = 1'b1; irq_lvl = 1'b0; brk_req = 1'b0; st_in = 8'h00; pc_in = 16'h0100; sp_in = 8'h90;
        @(negedge clk);
        boundary = 1'b1;
        @(negedge clk);
        boundary = 1'b0;
        chk("R8 edge taken", 32'(busy), 32'd1);
        repeat (7) @(negedge clk);
        chk("R8 entry done", 32'(done), 32'd1);
        chk("R8 non-maskable vector", 32'(pc_out), 32'h2211);
        @(negedge clk);
        boundary = 1'b1;
        @(negedge clk);
        boundary = 1'b0;
        chk("R8 held level does not retrigger", 32'(busy), 32'd0);
        nmi_req = 1'b0;

        // R9: a maskable pulse that drops before the boundary is not remembered.
        @(negedge clk);
        irq_lvl = 1'b1; st_in = 8'h00;
        @(negedge clk);
        irq_lvl = 1'b0; boundary = 1'b1;
        @(negedge clk);
        boundary = 1'b0;
        chk("R9 dropped level not latched", 32'(busy), 32'd0);

        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule